// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches page mappings in a small fully associative array. Each slot holds a virtual page tag, a physical page number, a set of permission bits, an address-space identifier and a global flag. A lookup takes a virtual page number and the current address-space identifier. In the same cycle it returns a hit flag, the physical page and the permission bits of the matching slot.

Slots are filled in round-robin order. A rotating victim pointer names the slot that the next fill overwrites. Four maintenance commands modify the array:
- clear every slot,
- drop only entries that belong to a process (non-global),
- drop the entries that would match one page in one address space,
- read the slot under the victim pointer, optionally stepping the pointer afterwards.

Commands arrive on a one-hot-free encoded opcode and take effect at the next clock edge. Lookups are purely combinational.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every slot is invalid, so no lookup hits, and the victim pointer `vict_idx` is 0.
- R2: A lookup hits only when a slot is valid, its tag equals `lk_vpn`, and either the slot's global flag is set or its stored identifier equals `lk_asid`. On a hit, `lk_ppn` and `lk_perm` come from that slot. On a miss, both outputs are zero.
- R3: When several slots match, the lowest-indexed slot supplies the result. `lk_hit` is a single bit.
- R4: Opcode 1 (fill) writes `cmd_vpn`, `cmd_asid`, `cmd_glob`, `cmd_ppn` and `cmd_perm` into the slot at `vict_idx`, overwriting any entry there. It marks the slot valid and advances the pointer by one.
- R5: The victim pointer wraps from slot ENTRIES-1 back to 0.
- R6: Opcode 2 (clear all) invalidates every slot and sets the pointer to 0.
- R7: Opcode 3 (drop process) invalidates every slot whose global flag is clear. Global slots keep translating, and the pointer is unchanged.
- R8: Opcode 4 (drop page) invalidates exactly those slots that the R2 rule would match for `cmd_vpn` and `cmd_asid`. Other slots and the pointer are unchanged.
- R9: `rd_ppn`, `rd_vld` and `rd_glob` always show the slot at the pointer. Opcode 5 advances the pointer and changes no slot. Opcode 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| lk_vpn | input | VPN_W | lookup virtual page |
| lk_asid | input | ASID_W | lookup address-space id |
| lk_hit | output | 1 | lookup hit |
| lk_ppn | output | PPN_W | translated physical page |
| lk_perm | output | PERM_W | permission bits of hit slot |
| cmd_op | input | 3 | 0 idle,1 fill,2 clear all,3 drop process,4 drop page,5 step pointer |
| cmd_vpn | input | VPN_W | fill / drop-page virtual page |
| cmd_asid | input | ASID_W | fill / drop-page address-space id |
| cmd_glob | input | 1 | fill global flag |
| cmd_ppn | input | PPN_W | fill physical page |
| cmd_perm | input | PERM_W | fill permission bits |
| vict_idx | output | IDX_W | current victim pointer |
| rd_vld | output | 1 | valid flag of slot at pointer |
| rd_glob | output | 1 | global flag of slot at pointer |
| rd_ppn | output | PPN_W | physical page of slot at pointer |

## Verification
The assertions assume that `cmd_op` never carries the codes 6 or 7. The stimulus draws only from the six defined codes.

The checks on pointer motion assume the pointer moves only on a fill or a step command. The bench issues commands one per cycle and samples results on the falling edge, so each effect is seen one edge after it is issued.

Duplicate mappings are created on purpose, by filling the same page twice, to exercise the lowest-index rule. This is the only situation in which the bench allows several slots to match.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_FILL  = 3'd1,
    OP_CLR   = 3'd2,
    OP_PROC  = 3'd3,
    OP_PAGE  = 3'd4,
    OP_STEP  = 3'd5
  } xop_e;

  function automatic logic slot_match(input logic vld, input logic glob,
                                      input logic tag_eq, input logic asid_eq);
    return vld && tag_eq && (glob || asid_eq);
  endfunction
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             zero,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] cur);
    return (cur == LAST) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || zero) idx <= '0;
    else if (step)      idx <= next_idx(idx);
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !zero && idx == LAST) |=> idx == '0); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !zero) |=> $stable(idx)); // R9
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 8,
  parameter int ASID_W = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]              q_vpn,
  input  logic [ASID_W-1:0]             q_asid,
  output logic [ENTRIES-1:0]            hits,
  output logic                          any,
  output logic [IDX_W-1:0]              first
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hits[i] = xlat_pkg::slot_match(vld[i], glob[i],
                       tag[i] == q_vpn, asid[i] == q_asid);
  end

  always_comb begin
    first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hits[i]) first = IDX_W'(i);
  end
  assign any = |hits;

  always_comb begin
    if (any) AST_FIRST_LOW: assert (hits[first] && ((hits & ((ENTRIES'(1) << first) - 1'b1)) == '0)); // R3
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 8,
  parameter int PPN_W = 8,
  parameter int ASID_W = 4,
  parameter int PERM_W = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic [2:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_glob,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [PERM_W-1:0] cmd_perm,
  output logic [IDX_W-1:0]  vict_idx,
  output logic              rd_vld,
  output logic              rd_glob,
  output logic [PPN_W-1:0]  rd_ppn
);
  import xlat_pkg::*;

  logic [ENTRIES-1:0]             v_q, g_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  // named events
  logic ev_fill, ev_clr, ev_proc, ev_page, ev_step;
  assign ev_fill = cmd_op == OP_FILL;
  assign ev_clr  = cmd_op == OP_CLR;
  assign ev_proc = cmd_op == OP_PROC;
  assign ev_page = cmd_op == OP_PAGE;
  assign ev_step = cmd_op == OP_STEP;

  logic [ENTRIES-1:0] lk_hits, pg_hits;
  logic               lk_any, pg_any;
  logic [IDX_W-1:0]   lk_idx, pg_idx;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk (
    .vld(v_q), .glob(g_q), .tag(tag_q), .asid(asid_q),
    .q_vpn(lk_vpn), .q_asid(lk_asid),
    .hits(lk_hits), .any(lk_any), .first(lk_idx));

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pg (
    .vld(v_q), .glob(g_q), .tag(tag_q), .asid(asid_q),
    .q_vpn(cmd_vpn), .q_asid(cmd_asid),
    .hits(pg_hits), .any(pg_any), .first(pg_idx));

  xlat_victim #(.ENTRIES(ENTRIES)) u_vict (
    .clk(clk), .rst_n(rst_n), .step(ev_fill || ev_step), .zero(ev_clr),
    .idx(vict_idx));

  assign lk_hit  = lk_any;
  assign lk_ppn  = lk_any ? ppn_q[lk_idx]  : '0;
  assign lk_perm = lk_any ? perm_q[lk_idx] : '0;

  assign rd_vld  = v_q[vict_idx];
  assign rd_glob = g_q[vict_idx];
  assign rd_ppn  = ppn_q[vict_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_here;
    assign wr_here = ev_fill && (vict_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0; g_q[i] <= 1'b0; tag_q[i] <= '0;
        asid_q[i] <= '0; ppn_q[i] <= '0; perm_q[i] <= '0;
      end else if (ev_clr) begin
        v_q[i] <= 1'b0; g_q[i] <= 1'b0; tag_q[i] <= '0;
        asid_q[i] <= '0; ppn_q[i] <= '0; perm_q[i] <= '0;
      end else if (ev_proc) begin
        if (!g_q[i]) v_q[i] <= 1'b0;
      end else if (ev_page) begin
        if (pg_hits[i]) v_q[i] <= 1'b0;
      end else if (wr_here) begin
        v_q[i] <= 1'b1; g_q[i] <= cmd_glob; tag_q[i] <= cmd_vpn;
        asid_q[i] <= cmd_asid; ppn_q[i] <= cmd_ppn; perm_q[i] <= cmd_perm;
      end
    end
  end

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op <= 3'd5); // R9
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> v_q[$past(vict_idx)]); // R4
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> (v_q == '0 && vict_idx == '0)); // R6
  AST_PROC_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proc |=> ((v_q & ~g_q) == '0)); // R7
  AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_page && pg_any) |=> !v_q[$past(pg_idx)]); // R8
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> v_q[lk_idx]); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && lk_perm == '0)); // R2
endmodule

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [7:0] lk_vpn = 0, cmd_vpn = 0, cmd_ppn = 0;
  logic [3:0] lk_asid = 0, cmd_asid = 0, cmd_perm = 0;
  logic [2:0] cmd_op = 0;
  logic cmd_glob = 0;
  logic lk_hit, rd_vld, rd_glob;
  logic [7:0] lk_ppn, rd_ppn;
  logic [3:0] lk_perm;
  logic [2:0] vict_idx;

  xlat_buffer u0 (.*);

  int checks = 0, errors = 0;
  int cyc = 0;

  // independent model
  logic       m_v[N], m_g[N];
  logic [7:0] m_t[N], m_p[N];
  logic [3:0] m_a[N], m_pm[N];
  int         m_ptr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] m_look(input logic [7:0] vp, input logic [3:0] as);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_t[i] == vp && (m_g[i] || m_a[i] == as))
        return {1'b1, m_p[i], m_pm[i]};
    return '0;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [7:0] vp, input logic [3:0] as,
                       input logic gl, input logic [7:0] pp, input logic [3:0] pm);
    cmd_op = op; cmd_vpn = vp; cmd_asid = as; cmd_glob = gl; cmd_ppn = pp; cmd_perm = pm;
    @(posedge clk); #1;
    case (op)
      3'd1: begin m_v[m_ptr]=1; m_g[m_ptr]=gl; m_t[m_ptr]=vp; m_a[m_ptr]=as;
                  m_p[m_ptr]=pp; m_pm[m_ptr]=pm; m_ptr=(m_ptr+1)%N; end
      3'd2: begin for (int i=0;i<N;i++) begin m_v[i]=0; m_g[i]=0; m_p[i]=0; end m_ptr=0; end
      3'd3: for (int i=0;i<N;i++) if (!m_g[i]) m_v[i]=0;
      3'd4: for (int i=0;i<N;i++) if (m_v[i] && m_t[i]==vp && (m_g[i]||m_a[i]==as)) m_v[i]=0;
      3'd5: m_ptr=(m_ptr+1)%N;
      default: ;
    endcase
    cmd_op = 0;
  endtask

  task automatic probe(input string req, input logic [7:0] vp, input logic [3:0] as);
    logic [12:0] e;
    lk_vpn = vp; lk_asid = as; #1;
    e = m_look(vp, as);
    chk(req, {19'd0, lk_hit, lk_ppn, lk_perm}, {19'd0, e});
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 12; v++)
      for (int a = 0; a < 4; a++) probe(req, 8'(v), 4'(a));
    chk(req, vict_idx, m_ptr);
    chk(req, {rd_vld, rd_glob, rd_ppn}, {m_v[m_ptr], m_g[m_ptr], m_p[m_ptr]});
  endtask

  initial begin
    fork
      begin
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        errors++; $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
      end
    join_none
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i]=0; m_g[i]=0; m_t[i]=0; m_a[i]=0; m_p[i]=0; m_pm[i]=0; end
    m_ptr = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    sweep("R1");
    // fill: vpn i, asid i%4, global on i==3
    for (int i = 0; i < N; i++) issue(3'd1, 8'(i), 4'(i%4), i==3, 8'(8'h40+i), 4'(i));
    @(negedge clk); sweep("R2");
    chk("R5", vict_idx, 0);
    // overwrite slot 0 (R4) and duplicate vpn 5 in slot 1 asid 1 (R3)
    issue(3'd1, 8'd9, 4'd2, 0, 8'h99, 4'hA);
    issue(3'd1, 8'd5, 4'd1, 1, 8'h55, 4'h5);
    @(negedge clk); sweep("R4");
    probe("R3", 8'd5, 4'd1);
    chk("R3", lk_ppn, 8'h55);
    // step pointer
    issue(3'd5, 0, 0, 0, 0, 0);
    @(negedge clk); sweep("R9");
    issue(3'd0, 0, 0, 0, 0, 0);
    @(negedge clk); sweep("R9");
    // drop page
    issue(3'd4, 8'd5, 4'd1, 0, 0, 0);
    @(negedge clk); sweep("R8");
    issue(3'd4, 8'd6, 4'd3, 0, 0, 0);
    @(negedge clk); sweep("R8");
    // drop process
    issue(3'd3, 0, 0, 0, 0, 0);
    @(negedge clk); sweep("R7");
    probe("R7", 8'd3, 4'd0);
    chk("R7", lk_hit, 1);
    // wrap test across many fills
    for (int i = 0; i < 13; i++) issue(3'd1, 8'(i), 4'd2, i[0], 8'(i*3), 4'(i));
    @(negedge clk); sweep("R5");
    issue(3'd2, 0, 0, 0, 0, 0);
    @(negedge clk); sweep("R6");
    chk("R6", vict_idx, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule